// File: doc/BRIEF.md
# Genlockable Video Timing Counter

This block keeps the dot, line and field position of a standard-definition raster. It runs in one of two modes. With lock enabled, it follows separated horizontal and vertical sync strobes from one of two video sources. It re-phases its dot counter on each horizontal strobe and restarts a field on each vertical strobe. With lock disabled, it counts from the local clock alone, and every sync input is ignored.

A software timing-reset strobe sends the raster to its origin. The origin is dot 0 of line 1 in the first field. Used while free-running, this strobe lets the timing be started from an outside event instead of from video. The standard (525 or 625 lines, each with its own dots-per-line parameter) and the sync source are both sampled only when a new field begins, so a field is never cut short. A lock indicator reports whether the selected source's horizontal sync lands close to where the counter expects it.

Top module: `genlock_timing`

## Requirements
- R1: While reset is held, and at the first sample after it, the outputs are dot_o=0, line_o=1, field_o=0 (first field), field_start_o=1 and locked_o=0.
- R2: Free-running NTSC counts dots from 0 to DOTS_NTSC-1 and then moves to the next line. Lines 1..263 carry field_o=0, lines 264..525 carry field_o=1, and line 525 wraps to line 1.
- R3: While lock_en_i=0, every hs/vs input is ignored and the dot count advances by one each cycle.
- R4: tres_i=1 sets dot 0, line 1, field_o=0 on the next cycle. This takes priority over any sync strobe in the same cycle.
- R5: src_sel_i=0 selects hs_a_i/vs_a_i and src_sel_i=1 selects hs_b_i/vs_b_i. A new value only takes effect when a field starts, through a line wrap, a vertical strobe or tres_i.
- R6: pal_sel_i=1 selects 625 lines and DOTS_PAL dots per line, with field_o=0 for lines 1..313 and field_o=1 for lines 314..625. pal_sel_i=0 selects the NTSC layout. A change takes effect only when the next field starts.
- R7: In locked mode a selected horizontal strobe sets the dot count to 0 on the next cycle. If it arrives at dot >= half the line length it also advances the line. Otherwise the line is kept.
- R8: In locked mode a selected vertical strobe sets the dot to 0 and returns to the first line of a field. If the current line index within the field is at least half the field length, the next field starts. Otherwise the current field restarts.
- R9: A selected horizontal strobe is on time when the dot is within the last SYNC_TOL+1 dots of the line or below SYNC_TOL. locked_o rises after LOCK_RUN consecutive on-time strobes. It falls after LOCK_RUN consecutive misses; a miss is an off-time strobe, or a line whose dot reaches SYNC_TOL without a strobe. lock_en_i=0 clears locked_o.
- R10: field_start_o is 1 exactly when the dot is 0 on the first line of either field.
- R11: When selected vertical and horizontal strobes arrive together, the vertical rule of R8 decides the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lock_en_i | input | 1 | 1 follows input sync, 0 free-runs |
| src_sel_i | input | 1 | Sync source request, 0 = A, 1 = B |
| pal_sel_i | input | 1 | Standard request, 1 = 625-line, 0 = 525-line |
| tres_i | input | 1 | Timing-reset strobe to raster origin |
| hs_a_i | input | 1 | Horizontal sync strobe, source A |
| vs_a_i | input | 1 | Vertical sync strobe, source A |
| hs_b_i | input | 1 | Horizontal sync strobe, source B |
| vs_b_i | input | 1 | Vertical sync strobe, source B |
| dot_o | output | CNT_W | Dot within line |
| line_o | output | 10 | Frame line number, from 1 |
| field_o | output | 1 | 0 = first field, 1 = second field |
| field_start_o | output | 1 | High at dot 0 of a field's first line |
| locked_o | output | 1 | Sync lock indicator |

## Verification
Several functions can fall in the same cycle: the timing reset against a vertical and a horizontal strobe, and a vertical strobe against a horizontal one. The bench drives these strobes on one edge, at chosen dots and lines. It then reads the next position against the priority order: the timing reset wins first, and the vertical rule wins over the horizontal one. A second collision is a configuration request that arrives mid-field while a strobe is pending. The bench checks that the strobe still acts on the old source, or that the old line length holds, until a field boundary passes.

// File: rtl/genlock_pkg.sv
package genlock_pkg;

    localparam int LINE_W        = 10;
    localparam int NTSC_F1_LINES = 263;
    localparam int NTSC_F2_LINES = 262;
    localparam int PAL_F1_LINES  = 313;
    localparam int PAL_F2_LINES  = 312;

    typedef enum logic {STD_NTSC = 1'b0, STD_PAL = 1'b1} vstd_e;
    typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} vsrc_e;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        vstd_e std;
        vsrc_e src;
    } vcfg_t;

    typedef struct packed {
        logic  field;
        line_t lif;
    } vpos_t;

    function automatic line_t field_lines(vstd_e s, logic f);
        line_t n;
        if (s == STD_PAL) n = f ? line_t'(PAL_F2_LINES)  : line_t'(PAL_F1_LINES);
        else              n = f ? line_t'(NTSC_F2_LINES) : line_t'(NTSC_F1_LINES);
        return n;
    endfunction

    function automatic line_t first_line(vstd_e s, logic f);
        return f ? field_lines(s, 1'b0) + line_t'(1) : line_t'(1);
    endfunction

endpackage

// File: rtl/genlock_sync_sel.sv
module genlock_sync_sel
    import genlock_pkg::*;
(
    input  logic       lock_en_i,
    input  vsrc_e      src_i,
    input  logic [1:0] hs_in_i,
    input  logic [1:0] vs_in_i,
    output logic       hs_o,
    output logic       vs_o
);
    logic idx;
    assign idx  = (src_i == SRC_B);
    assign hs_o = lock_en_i & hs_in_i[idx];
    assign vs_o = lock_en_i & vs_in_i[idx];
endmodule

// File: rtl/genlock_counter.sv
module genlock_counter
    import genlock_pkg::*;
#(
    parameter int DOTS_NTSC = 858,
    parameter int DOTS_PAL  = 864,
    parameter int CNT_W     = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tres_i,
    input  logic             hs_i,
    input  logic             vs_i,
    input  vcfg_t            cfg_req_i,
    output logic [CNT_W-1:0] dot_o,
    output logic [CNT_W-1:0] dpl_o,
    output vpos_t            pos_o,
    output vcfg_t            cfg_o
);
    logic [CNT_W-1:0] dot_q, dot_n, dpl;
    vpos_t            pos_q, pos_n, pos_step;
    vcfg_t            cfg_q;
    logic             load, step_load;
    line_t            flen;

    assign dpl  = (cfg_q.std == STD_PAL) ? CNT_W'(DOTS_PAL) : CNT_W'(DOTS_NTSC);
    assign flen = field_lines(cfg_q.std, pos_q.field);

    // position after one line step, including the field wrap
    always_comb begin
        pos_step  = pos_q;
        step_load = 1'b0;
        if (pos_q.lif == flen - line_t'(1)) begin
            pos_step.field = ~pos_q.field;
            pos_step.lif   = '0;
            step_load      = 1'b1;
        end else begin
            pos_step.lif = pos_q.lif + line_t'(1);
        end
    end

    // priority: timing reset, vertical strobe, horizontal strobe, free count
    always_comb begin
        dot_n = dot_q;
        pos_n = pos_q;
        load  = 1'b0;
        if (tres_i) begin
            dot_n = '0;
            pos_n = '0;
            load  = 1'b1;
        end else if (vs_i) begin
            dot_n     = '0;
            pos_n.lif = '0;
            if (pos_q.lif >= (flen >> 1)) begin
                pos_n.field = ~pos_q.field;
                load        = 1'b1;
            end
        end else if (hs_i) begin
            dot_n = '0;
            if (dot_q >= (dpl >> 1)) begin
                pos_n = pos_step;
                load  = step_load;
            end
        end else if (dot_q == dpl - CNT_W'(1)) begin
            dot_n = '0;
            pos_n = pos_step;
            load  = step_load;
        end else begin
            dot_n = dot_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dot_q <= '0;
            pos_q <= '0;
            cfg_q <= cfg_req_i;
        end else begin
            dot_q <= dot_n;
            pos_q <= pos_n;
            if (load) cfg_q <= cfg_req_i;
        end
    end

    assign dot_o = dot_q;
    assign dpl_o = dpl;
    assign pos_o = pos_q;
    assign cfg_o = cfg_q;
endmodule

// File: rtl/genlock_lock_det.sv
module genlock_lock_det #(
    parameter int CNT_W = 10,
    parameter int TOL   = 2,
    parameter int RUN   = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             hs_i,
    input  logic [CNT_W-1:0] dot_i,
    input  logic [CNT_W-1:0] dpl_i,
    output logic             locked_o
);
    localparam int          RUN_W = $clog2(RUN + 1);
    localparam logic [31:0] TOL_U = 32'(TOL);

    logic [RUN_W-1:0] hit_q, miss_q;
    logic             seen_q, locked_q;
    logic             in_win, at_close, evt_hit, evt_miss;

    assign in_win   = (32'(dot_i) + TOL_U + 32'd1 >= 32'(dpl_i)) || (32'(dot_i) < TOL_U);
    assign at_close = (32'(dot_i) == TOL_U);
    assign evt_hit  = en_i && hs_i && in_win;
    assign evt_miss = en_i && ((hs_i && !in_win) || (!hs_i && at_close && !seen_q));

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            hit_q    <= '0;
            miss_q   <= '0;
            seen_q   <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            if (hs_i)          seen_q <= 1'b1;
            else if (at_close) seen_q <= 1'b0;
            if (evt_hit) begin
                miss_q <= '0;
                if (hit_q != RUN_W'(RUN)) hit_q <= hit_q + RUN_W'(1);
                if (hit_q >= RUN_W'(RUN - 1)) locked_q <= 1'b1;
            end
            if (evt_miss) begin
                hit_q <= '0;
                if (miss_q != RUN_W'(RUN)) miss_q <= miss_q + RUN_W'(1);
                if (miss_q >= RUN_W'(RUN - 1)) locked_q <= 1'b0;
            end
        end
    end

    assign locked_o = locked_q;
endmodule

// File: rtl/genlock_timing.sv
module genlock_timing
    import genlock_pkg::*;
#(
    parameter int  DOTS_NTSC = 858,
    parameter int  DOTS_PAL  = 864,
    parameter int  SYNC_TOL  = 2,
    parameter int  LOCK_RUN  = 4,
    localparam int DOTS_MAX  = (DOTS_PAL > DOTS_NTSC) ? DOTS_PAL : DOTS_NTSC,
    localparam int DOTS_MIN  = (DOTS_PAL > DOTS_NTSC) ? DOTS_NTSC : DOTS_PAL,
    localparam int CNT_W     = $clog2(DOTS_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              lock_en_i,
    input  logic              src_sel_i,
    input  logic              pal_sel_i,
    input  logic              tres_i,
    input  logic              hs_a_i,
    input  logic              vs_a_i,
    input  logic              hs_b_i,
    input  logic              vs_b_i,
    output logic [CNT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              field_start_o,
    output logic              locked_o
);
    vcfg_t            cfg_req, cfg_act;
    vpos_t            pos;
    logic [CNT_W-1:0] dot, dpl;
    logic             hs_sel, vs_sel;

    assign cfg_req.std = vstd_e'(pal_sel_i);
    assign cfg_req.src = vsrc_e'(src_sel_i);

    genlock_sync_sel u_sel (
        .lock_en_i (lock_en_i),
        .src_i     (cfg_act.src),
        .hs_in_i   ({hs_b_i, hs_a_i}),
        .vs_in_i   ({vs_b_i, vs_a_i}),
        .hs_o      (hs_sel),
        .vs_o      (vs_sel)
    );

    genlock_counter #(
        .DOTS_NTSC (DOTS_NTSC),
        .DOTS_PAL  (DOTS_PAL),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tres_i    (tres_i),
        .hs_i      (hs_sel),
        .vs_i      (vs_sel),
        .cfg_req_i (cfg_req),
        .dot_o     (dot),
        .dpl_o     (dpl),
        .pos_o     (pos),
        .cfg_o     (cfg_act)
    );

    genlock_lock_det #(
        .CNT_W (CNT_W),
        .TOL   (SYNC_TOL),
        .RUN   (LOCK_RUN)
    ) u_lock (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (lock_en_i),
        .hs_i     (hs_sel),
        .dot_i    (dot),
        .dpl_i    (dpl),
        .locked_o (locked_o)
    );

    assign dot_o         = dot;
    assign line_o        = pos.lif + first_line(cfg_act.std, pos.field);
    assign field_o       = pos.field;
    assign field_start_o = (dot == '0) && (pos.lif == '0);
endmodule

// File: rtl/genlock_timing_chk.sv
module genlock_timing_chk #(
    parameter int DMIN  = 858,
    parameter int DMAX  = 864,
    parameter int CNT_W = 10
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             tres_i,
    input logic             lock_en_i,
    input logic             hs_sel,
    input logic             vs_sel,
    input logic [CNT_W-1:0] dot_o,
    input logic [9:0]       line_o,
    input logic             field_o,
    input logic             field_start_o,
    input logic             locked_o
);
    assert_tres_origin_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        tres_i |=> (dot_o == '0 && line_o == 10'd1 && !field_o));

    assert_ignore_sync_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!lock_en_i && !tres_i && dot_o < CNT_W'(DMIN - 1)) |=> (dot_o == $past(dot_o) + CNT_W'(1)));

    assert_dot_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        dot_o < CNT_W'(DMAX));

    assert_hsync_dot_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (hs_sel && !vs_sel && !tres_i) |=> (dot_o == '0));

    assert_vsync_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (vs_sel && !tres_i) |=> field_start_o);

    assert_lock_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !lock_en_i |=> !locked_o);

    assert_lock_needs_sync_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(locked_o) |-> $past(hs_sel));

    assert_field_edge_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $changed(field_o) |-> field_start_o);
endmodule

bind genlock_timing genlock_timing_chk #(
    .DMIN  (DOTS_MIN),
    .DMAX  (DOTS_MAX),
    .CNT_W (CNT_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .tres_i        (tres_i),
    .lock_en_i     (lock_en_i),
    .hs_sel        (hs_sel),
    .vs_sel        (vs_sel),
    .dot_o         (dot_o),
    .line_o        (line_o),
    .field_o       (field_o),
    .field_start_o (field_start_o),
    .locked_o      (locked_o)
);

// File: tb/genlock_timing_tb_top.sv
`timescale 1ns/100ps
module genlock_timing_tb_top;
    localparam int DN    = 20;
    localparam int DP    = 24;
    localparam int TOL   = 2;
    localparam int RUN   = 4;
    localparam int CNT_W = $clog2(DP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_en = 0, src = 0, pal = 0, tres = 0;
    logic ha = 0, va = 0, hb = 0, vb = 0;
    logic [CNT_W-1:0] dot_o;
    logic [9:0]       line_o;
    logic             field_o, field_start_o, locked_o;

    always #2.5 clk = ~clk;

    genlock_timing #(.DOTS_NTSC(DN), .DOTS_PAL(DP), .SYNC_TOL(TOL), .LOCK_RUN(RUN)) dut_i (
        .clk_i(clk), .rst_i(rst), .lock_en_i(lock_en), .src_sel_i(src), .pal_sel_i(pal),
        .tres_i(tres), .hs_a_i(ha), .vs_a_i(va), .hs_b_i(hb), .vs_b_i(vb),
        .dot_o(dot_o), .line_o(line_o), .field_o(field_o),
        .field_start_o(field_start_o), .locked_o(locked_o)
    );

    int    nchk = 0, nerr = 0;
    string cur_req = "R1";
    bit    started = 0;

    // behavioural reference state
    int m_dot, m_lif, m_field, m_pal, m_src, m_seen, m_hit, m_miss, m_lock;

    function automatic int fl(int p, int f);
        if (p != 0) return (f != 0) ? 312 : 313;
        return (f != 0) ? 262 : 263;
    endfunction

    function automatic int m_line();
        return m_lif + 1 + ((m_field != 0) ? fl(m_pal, 0) : 0);
    endfunction

    function automatic int m_dpl();
        return (m_pal != 0) ? DP : DN;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int dpl, flen, hs_s, vs_s, inw;
        if (rst) begin
            m_dot = 0; m_lif = 0; m_field = 0; m_pal = pal; m_src = src;
            m_seen = 0; m_hit = 0; m_miss = 0; m_lock = 0;
        end else begin
            dpl  = m_dpl();
            flen = fl(m_pal, m_field);
            hs_s = (lock_en && ((m_src != 0) ? hb : ha)) ? 1 : 0;
            vs_s = (lock_en && ((m_src != 0) ? vb : va)) ? 1 : 0;
            inw  = ((m_dot + TOL + 1 >= dpl) || (m_dot < TOL)) ? 1 : 0;
            // lock rule, on the position before this edge
            if (!lock_en) begin
                m_seen = 0; m_hit = 0; m_miss = 0; m_lock = 0;
            end else if (hs_s != 0) begin
                m_seen = 1;
                if (inw != 0) begin
                    m_miss = 0; if (m_hit < RUN) m_hit++; if (m_hit >= RUN) m_lock = 1;
                end else begin
                    m_hit = 0; if (m_miss < RUN) m_miss++; if (m_miss >= RUN) m_lock = 0;
                end
            end else if (m_dot == TOL) begin
                if (m_seen == 0) begin
                    m_hit = 0; if (m_miss < RUN) m_miss++; if (m_miss >= RUN) m_lock = 0;
                end
                m_seen = 0;
            end
            // position rule
            if (tres) begin
                m_dot = 0; m_lif = 0; m_field = 0; m_pal = pal; m_src = src;
            end else if (vs_s != 0) begin
                m_dot = 0;
                if (m_lif >= flen / 2) begin
                    m_field = 1 - m_field; m_pal = pal; m_src = src;
                end
                m_lif = 0;
            end else if (hs_s != 0 || m_dot == dpl - 1) begin
                if (hs_s == 0 || m_dot >= dpl / 2) begin
                    if (m_lif == flen - 1) begin
                        m_lif = 0; m_field = 1 - m_field; m_pal = pal; m_src = src;
                    end else m_lif++;
                end
                m_dot = 0;
            end else begin
                m_dot++;
            end
            started = 1;
        end
    end

    // compare with the reference on every clock
    always @(negedge clk) begin
        if (started && !rst) begin
            chk(cur_req, "dot_o", int'(dot_o), m_dot);
            chk(cur_req, "line_o", int'(line_o), m_line());
            chk(cur_req, "field_o", int'(field_o), m_field);
            chk(cur_req, "field_start_o", int'(field_start_o), (m_dot == 0 && m_lif == 0) ? 1 : 0);
            chk(cur_req, "locked_o", int'(locked_o), m_lock);
        end
    end

    task automatic wait_dot(input int d);
        while (m_dot != d) @(negedge clk);
    endtask

    task automatic wait_pos(input int l, input int d);
        while (!(m_line() == l && m_dot == d)) @(negedge clk);
    endtask

    task automatic set_hs(input logic v);
        if (m_src != 0) hb = v; else ha = v;
    endtask

    // off <= 0: strobe -off dots early; off > 0: strobe off dots late
    task automatic hs_lines(input int n, input int off);
        for (int i = 0; i < n; i++) begin
            int tgt;
            wait_dot(m_dpl() / 2);
            @(negedge clk);
            tgt = (off <= 0) ? m_dpl() - 1 + off : off - 1;
            wait_dot(tgt);
            set_hs(1'b1);
            @(negedge clk);
            set_hs(1'b0);
        end
    endtask

    initial begin
        int l0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "dot_o", int'(dot_o), 0);
        chk("R1", "line_o", int'(line_o), 1);
        chk("R1", "field_o", int'(field_o), 0);
        chk("R1", "field_start_o", int'(field_start_o), 1);
        chk("R1", "locked_o", int'(locked_o), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "line_o after release", int'(line_o), 1);

        // R2 free-run NTSC, R10 field-start
        cur_req = "R2";
        wait_pos(263, DN - 1);
        @(negedge clk);
        chk("R2", "line after 263", int'(line_o), 264);
        chk("R2", "field at 264", int'(field_o), 1);
        chk("R10", "field_start at 264", int'(field_start_o), 1);
        wait_pos(525, DN - 1);
        @(negedge clk);
        chk("R2", "line after 525", int'(line_o), 1);
        chk("R2", "field at 1", int'(field_o), 0);
        @(negedge clk);
        chk("R10", "field_start at dot 1", int'(field_start_o), 0);

        // R3 sync ignored while free-running
        cur_req = "R3";
        for (int i = 0; i < 200; i++) begin
            ha = (i % 7 == 0); hb = (i % 5 == 0); va = (i % 50 == 3); vb = (i % 60 == 9);
            @(negedge clk);
        end
        ha = 0; hb = 0; va = 0; vb = 0;
        wait_dot(4);
        ha = 1; va = 1; hb = 1; vb = 1;
        @(negedge clk);
        ha = 0; va = 0; hb = 0; vb = 0;
        chk("R3", "dot after ignored strobes", int'(dot_o), 5);

        // R4 timing reset beats strobes
        cur_req = "R4";
        lock_en = 1;
        wait_pos(40, 7);
        tres = 1; ha = 1; va = 1;
        @(negedge clk);
        tres = 0; ha = 0; va = 0;
        chk("R4", "dot", int'(dot_o), 0);
        chk("R4", "line", int'(line_o), 1);
        chk("R4", "field", int'(field_o), 0);

        // R9 lock acquisition and loss
        cur_req = "R9";
        hs_lines(3, 0);
        chk("R9", "locked after 3 hits", int'(locked_o), 0);
        hs_lines(1, 0);
        chk("R9", "locked after 4 hits", int'(locked_o), 1);
        hs_lines(3, 2);
        hs_lines(2, -2);
        chk("R9", "locked with +-2 jitter", int'(locked_o), 1);
        hs_lines(3, -5);
        chk("R9", "locked after 3 misses", int'(locked_o), 1);
        hs_lines(1, -5);
        chk("R9", "locked after 4 misses", int'(locked_o), 0);
        hs_lines(4, 0);
        chk("R9", "relocked", int'(locked_o), 1);

        // R7 late strobe keeps line, early strobe advances it
        cur_req = "R7";
        wait_dot(1);
        l0 = int'(line_o);
        set_hs(1'b1);
        @(negedge clk);
        set_hs(1'b0);
        chk("R7", "dot after late strobe", int'(dot_o), 0);
        chk("R7", "line after late strobe", int'(line_o), l0);
        wait_dot(15);
        l0 = int'(line_o);
        set_hs(1'b1);
        @(negedge clk);
        set_hs(1'b0);
        chk("R7", "dot after early strobe", int'(dot_o), 0);
        chk("R7", "line after early strobe", int'(line_o), (l0 == 525) ? 1 : l0 + 1);

        cur_req = "R9";
        repeat (6 * DN) @(negedge clk);
        chk("R9", "unlocked with no sync", int'(locked_o), 0);
        lock_en = 0;
        @(negedge clk);
        lock_en = 1;

        // R5 source change held until a field start
        cur_req = "R5";
        src = 1;
        wait_dot(5);
        hb = 1;
        @(negedge clk);
        hb = 0;
        chk("R5", "pending B strobe ignored", int'(dot_o), 6);
        tres = 1;
        @(negedge clk);
        tres = 0;
        wait_dot(5);
        ha = 1;
        @(negedge clk);
        ha = 0;
        chk("R5", "A strobe ignored after switch", int'(dot_o), 6);
        wait_dot(5);
        hb = 1;
        @(negedge clk);
        hb = 0;
        chk("R5", "B strobe used after switch", int'(dot_o), 0);

        // R8 vertical strobe, R11 vertical beats horizontal
        cur_req = "R8";
        wait_pos(50, 3);
        vb = 1;
        @(negedge clk);
        vb = 0;
        chk("R8", "late vsync line", int'(line_o), 1);
        chk("R8", "late vsync field", int'(field_o), 0);
        wait_pos(200, 3);
        vb = 1;
        @(negedge clk);
        vb = 0;
        chk("R8", "early vsync line", int'(line_o), 264);
        chk("R8", "early vsync field", int'(field_o), 1);
        chk("R8", "early vsync dot", int'(dot_o), 0);
        cur_req = "R11";
        wait_pos(270, 7);
        vb = 1; hb = 1;
        @(negedge clk);
        vb = 0; hb = 0;
        chk("R11", "line with both strobes", int'(line_o), 264);
        chk("R11", "dot with both strobes", int'(dot_o), 0);

        // R6 standard change at the next field start
        cur_req = "R6";
        lock_en = 0; src = 0;
        pal = 1;
        wait_pos(300, DN - 1);
        @(negedge clk);
        chk("R6", "NTSC length kept mid-field", int'(dot_o), 0);
        chk("R6", "NTSC line kept mid-field", int'(line_o), 301);
        wait_pos(313, DP - 1);
        @(negedge clk);
        chk("R6", "PAL line 314", int'(line_o), 314);
        chk("R6", "PAL field 2", int'(field_o), 1);
        wait_pos(625, DP - 1);
        @(negedge clk);
        chk("R6", "PAL wrap", int'(line_o), 1);
        chk("R6", "PAL wrap field", int'(field_o), 0);

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule